// File: doc/BRIEF.md
# Cash Machine Transaction Controller

This block is the control core of a simulated cash machine. Sixteen slide switches and five single-cycle button pulses (up, down, left, right, centre) drive it. A session opens with an 8-bit PIN read from the switches. After that a five-entry service menu offers a balance inquiry, cash withdrawal, cash deposit, check deposit and PIN change. The controller holds the account balance and the stored PIN in its own registers. It enforces the banking rules: withdrawal granularity and limit, sufficient funds, a balance ceiling that voids a deposit, valid BCD digits on a check, and no reuse of the current PIN.

Its outputs are a binary amount for the display, a 4-bit message code and a blink enable. Debounced button pulses, binary-to-decimal conversion and seven-segment multiplexing are left to neighbouring blocks. After every accepted withdrawal or deposit, the moved amount blinks for a parameterised number of cycles (five seconds at the default clock). The new balance is then shown.

States: `ST_PIN` (PIN entry), `ST_MENU` (service selection), `ST_WDR` (withdrawal amount entry), `ST_DEP` (cash deposit amount entry), `ST_CHK` (check entry on switches), `ST_NEWPIN` (new PIN entry), `ST_BLINK` (timed confirmation) and `ST_RESULT` (balance, success or error screen).

Transitions:
- `ST_PIN` goes to `ST_MENU` on centre with a matching PIN.
- `ST_MENU` goes to `ST_RESULT` (balance inquiry), `ST_WDR`, `ST_DEP`, `ST_CHK` or `ST_NEWPIN` on centre.
- Each entry state goes to `ST_BLINK` on an accepted commit and to `ST_RESULT` on a rejected one.
- `ST_NEWPIN` goes to `ST_RESULT` on centre.
- `ST_BLINK` goes to `ST_RESULT` when the timer expires.
- `ST_RESULT` goes to `ST_MENU` on centre.

Top module: `atm_ctrl`

## Requirements
- R1: After reset the message code is 0 (PIN prompt), the amount is 0, blink is 0, the stored PIN is 8'h00 and the balance is `INIT_BALANCE`.
- R2: In PIN entry, centre compares `sw[7:0]` with the stored PIN. On a match the menu opens on balance inquiry (code 1). On a mismatch the block stays in PIN entry with code 9 until a correct entry.
- R3: In the menu the code is 1 + item, with items balance=0, withdraw=1, deposit=2, check=3, PIN change=4. Up steps forward and wraps from 4 to 0. Down steps backward and wraps from 0 to 4. Centre enters the selected service.
- R4: Balance inquiry shows code 6 with the balance as the amount. On any result screen, centre returns to the menu at the same item, and every other button is ignored.
- R5: In withdrawal or deposit entry the code is 7 and the amount starts at 0. Each pulse adds up=10, right=20, left=50, down=100. The total saturates at 2047 and never decreases while entry continues. If buttons coincide, priority is down, left, right, up.
- R6: A withdrawal that is not a multiple of 20 or exceeds 500 shows code 10 with the balance unchanged.
- R7: A withdrawal larger than the balance shows code 11 with the balance unchanged.
- R8: A valid withdrawal subtracts the amount. For exactly `BLINK_CYCLES` cycles, blink is 1, the code is 8 and the amount is the withdrawal, with the balance stable. Then code 6 shows the new balance.
- R9: A deposit (cash or check) that would take the balance above 1500 shows code 12 with the balance unchanged. The next deposit entry restarts at 0.
- R10: A valid cash deposit adds the total, blinks it as in R8, then shows the new balance.
- R11: A check is four BCD digits on `sw[15:0]`, most significant digit in `sw[15:12]`. Any digit above 9 shows code 14. A valid check is added under R9's ceiling and blinks as in R8.
- R12: In PIN change, centre with `sw[7:0]` equal to the stored PIN shows code 13 and keeps it. Otherwise the switches become the new PIN and code 15 is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw | input | 16 | Slide switches: PIN in bits 7:0, check digits in 15:0 |
| btn_up | input | 1 | Up pulse: menu forward, adds 10 |
| btn_down | input | 1 | Down pulse: menu backward, adds 100 |
| btn_left | input | 1 | Left pulse: adds 50 |
| btn_right | input | 1 | Right pulse: adds 20 |
| btn_ctr | input | 1 | Centre pulse: confirm, commit, return |
| disp_amount | output | 11 | Binary amount to display |
| msg_code | output | 4 | Screen message code |
| blink | output | 1 | Display blink enable |

## Verification
The bench builds the controller with `BLINK_CYCLES` set to 8 and `INIT_BALANCE` set to 300. With those values the whole confirmation window can be checked at its first cycle, its last cycle and the cycle after. A 400 withdrawal is legal under the limit yet exceeds the funds. A 1400 deposit crosses the 1500 ceiling. Twenty-one presses of 100 reach the 2047 saturation point within a short run.

// File: rtl/atm_pkg.sv
package atm_pkg;

    typedef enum logic [3:0] {
        ST_PIN,
        ST_MENU,
        ST_WDR,
        ST_DEP,
        ST_CHK,
        ST_NEWPIN,
        ST_BLINK,
        ST_RESULT
    } state_t;

    typedef enum logic [2:0] {
        SVC_BAL = 3'd0,
        SVC_WDR = 3'd1,
        SVC_DEP = 3'd2,
        SVC_CHK = 3'd3,
        SVC_PIN = 3'd4
    } svc_t;

    localparam logic [3:0] MSG_PIN_PROMPT = 4'd0;
    localparam logic [3:0] MSG_MENU_BASE  = 4'd1;
    localparam logic [3:0] MSG_BALANCE    = 4'd6;
    localparam logic [3:0] MSG_ENTER      = 4'd7;
    localparam logic [3:0] MSG_CONFIRM    = 4'd8;
    localparam logic [3:0] MSG_ERR_PIN    = 4'd9;
    localparam logic [3:0] MSG_ERR_AMT    = 4'd10;
    localparam logic [3:0] MSG_ERR_FUNDS  = 4'd11;
    localparam logic [3:0] MSG_ERR_CEIL   = 4'd12;
    localparam logic [3:0] MSG_ERR_SAME   = 4'd13;
    localparam logic [3:0] MSG_ERR_BCD    = 4'd14;
    localparam logic [3:0] MSG_PIN_DONE   = 4'd15;

    localparam int VAL_UP    = 10;
    localparam int VAL_RIGHT = 20;
    localparam int VAL_LEFT  = 50;
    localparam int VAL_DOWN  = 100;

endpackage

// File: rtl/atm_amount_acc.sv
module atm_amount_acc #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] total
);
    logic [W:0] sum;

    assign sum = {1'b0, total} + {1'b0, add_val};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            total <= '0;
        end else if (add_en) begin
            total <= sum[W] ? '1 : sum[W-1:0];
        end
    end
endmodule

// File: rtl/atm_bcd_decode.sv
module atm_bcd_decode #(
    parameter int DIGITS = 4,
    parameter int VAL_W  = 14
) (
    input  logic [4*DIGITS-1:0] bcd,
    output logic [VAL_W-1:0]    value,
    output logic                all_ok
);
    logic [DIGITS-1:0] dig_ok;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign dig_ok[g] = (bcd[4*g +: 4] <= 4'd9);
    end

    assign all_ok = &dig_ok;

    always_comb begin
        value = '0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            value = value * VAL_W'(10) + VAL_W'(bcd[4*i +: 4]);
        end
    end
endmodule

// File: rtl/atm_hold_timer.sv
module atm_hold_timer #(
    parameter int CYCLES = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/atm_ctrl.sv
module atm_ctrl
    import atm_pkg::*;
#(
    parameter int AMT_W        = 11,
    parameter int SW_W         = 16,
    parameter int PIN_W        = 8,
    parameter int BLINK_CYCLES = 500_000_000,
    parameter int INIT_BALANCE = 500,
    parameter int MAX_BALANCE  = 1500,
    parameter int WDR_LIMIT    = 500,
    parameter int WDR_STEP     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW_W-1:0]  sw,
    input  logic             btn_up,
    input  logic             btn_down,
    input  logic             btn_left,
    input  logic             btn_right,
    input  logic             btn_ctr,
    output logic [AMT_W-1:0] disp_amount,
    output logic [3:0]       msg_code,
    output logic             blink
);
    localparam int BCD_DIGITS = SW_W / 4;
    localparam int CHK_W      = $clog2(10 ** BCD_DIGITS);
    localparam int SUM_W      = ((CHK_W > AMT_W) ? CHK_W : AMT_W) + 1;

    localparam logic [AMT_W-1:0] LIMIT_V = AMT_W'(WDR_LIMIT);
    localparam logic [AMT_W-1:0] STEP_V  = AMT_W'(WDR_STEP);
    localparam logic [SUM_W-1:0] CEIL_V  = SUM_W'(MAX_BALANCE);

    state_t             state_q, state_d;
    svc_t               svc_q, svc_d;
    logic [AMT_W-1:0]   balance_q, balance_d;
    logic [PIN_W-1:0]   pin_q, pin_d;
    logic [3:0]         res_msg_q, res_msg_d;
    logic [AMT_W-1:0]   shown_q, shown_d;

    logic [AMT_W-1:0]   acc_total;
    logic [AMT_W-1:0]   add_val;
    logic               any_amt_btn;
    logic               acc_clr;
    logic               acc_add;
    logic [CHK_W-1:0]   chk_val;
    logic               chk_ok;
    logic               hold_done;
    logic [SUM_W-1:0]   dep_sum;
    logic [SUM_W-1:0]   chk_sum;
    logic               pin_match;

    // amount button decode, priority down > left > right > up
    always_comb begin
        if (btn_down) begin
            add_val = AMT_W'(VAL_DOWN);
        end else if (btn_left) begin
            add_val = AMT_W'(VAL_LEFT);
        end else if (btn_right) begin
            add_val = AMT_W'(VAL_RIGHT);
        end else begin
            add_val = AMT_W'(VAL_UP);
        end
    end

    assign any_amt_btn = btn_up | btn_down | btn_left | btn_right;
    assign acc_clr     = (state_q == ST_MENU);
    assign acc_add     = any_amt_btn && ((state_q == ST_WDR) || (state_q == ST_DEP));

    atm_amount_acc #(
        .W (AMT_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .add_en  (acc_add),
        .add_val (add_val),
        .total   (acc_total)
    );

    atm_bcd_decode #(
        .DIGITS (BCD_DIGITS),
        .VAL_W  (CHK_W)
    ) u_bcd (
        .bcd    (sw[4*BCD_DIGITS-1:0]),
        .value  (chk_val),
        .all_ok (chk_ok)
    );

    atm_hold_timer #(
        .CYCLES (BLINK_CYCLES)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_BLINK),
        .done  (hold_done)
    );

    assign dep_sum   = SUM_W'(balance_q) + SUM_W'(acc_total);
    assign chk_sum   = SUM_W'(balance_q) + SUM_W'(chk_val);
    assign pin_match = (sw[PIN_W-1:0] == pin_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_PIN;
            svc_q     <= SVC_BAL;
            balance_q <= AMT_W'(INIT_BALANCE);
            pin_q     <= '0;
            res_msg_q <= MSG_PIN_PROMPT;
            shown_q   <= '0;
        end else begin
            state_q   <= state_d;
            svc_q     <= svc_d;
            balance_q <= balance_d;
            pin_q     <= pin_d;
            res_msg_q <= res_msg_d;
            shown_q   <= shown_d;
        end
    end

    // next state and register updates
    always_comb begin
        state_d   = state_q;
        svc_d     = svc_q;
        balance_d = balance_q;
        pin_d     = pin_q;
        res_msg_d = res_msg_q;
        shown_d   = shown_q;
        unique case (state_q)
            ST_PIN: begin
                if (btn_ctr) begin
                    if (pin_match) begin
                        state_d = ST_MENU;
                        svc_d   = SVC_BAL;
                    end else begin
                        res_msg_d = MSG_ERR_PIN;
                    end
                end
            end
            ST_MENU: begin
                if (btn_ctr) begin
                    unique case (svc_q)
                        SVC_BAL: begin
                            state_d   = ST_RESULT;
                            res_msg_d = MSG_BALANCE;
                        end
                        SVC_WDR: state_d = ST_WDR;
                        SVC_DEP: state_d = ST_DEP;
                        SVC_CHK: state_d = ST_CHK;
                        SVC_PIN: state_d = ST_NEWPIN;
                        default: state_d = ST_MENU;
                    endcase
                end else if (btn_up) begin
                    svc_d = (svc_q == SVC_PIN) ? SVC_BAL : svc_t'(svc_q + 3'd1);
                end else if (btn_down) begin
                    svc_d = (svc_q == SVC_BAL) ? SVC_PIN : svc_t'(svc_q - 3'd1);
                end
            end
            ST_WDR: begin
                if (btn_ctr) begin
                    if (((acc_total % STEP_V) != '0) || (acc_total > LIMIT_V)) begin
                        state_d   = ST_RESULT;
                        res_msg_d = MSG_ERR_AMT;
                    end else if (acc_total > balance_q) begin
                        state_d   = ST_RESULT;
                        res_msg_d = MSG_ERR_FUNDS;
                    end else begin
                        state_d   = ST_BLINK;
                        balance_d = balance_q - acc_total;
                        shown_d   = acc_total;
                    end
                end
            end
            ST_DEP: begin
                if (btn_ctr) begin
                    if (dep_sum > CEIL_V) begin
                        state_d   = ST_RESULT;
                        res_msg_d = MSG_ERR_CEIL;
                    end else begin
                        state_d   = ST_BLINK;
                        balance_d = dep_sum[AMT_W-1:0];
                        shown_d   = acc_total;
                    end
                end
            end
            ST_CHK: begin
                if (btn_ctr) begin
                    if (!chk_ok) begin
                        state_d   = ST_RESULT;
                        res_msg_d = MSG_ERR_BCD;
                    end else if (chk_sum > CEIL_V) begin
                        state_d   = ST_RESULT;
                        res_msg_d = MSG_ERR_CEIL;
                    end else begin
                        state_d   = ST_BLINK;
                        balance_d = chk_sum[AMT_W-1:0];
                        shown_d   = AMT_W'(chk_val);
                    end
                end
            end
            ST_NEWPIN: begin
                if (btn_ctr) begin
                    state_d = ST_RESULT;
                    if (pin_match) begin
                        res_msg_d = MSG_ERR_SAME;
                    end else begin
                        pin_d     = sw[PIN_W-1:0];
                        res_msg_d = MSG_PIN_DONE;
                    end
                end
            end
            ST_BLINK: begin
                if (hold_done) begin
                    state_d   = ST_RESULT;
                    res_msg_d = MSG_BALANCE;
                end
            end
            ST_RESULT: begin
                if (btn_ctr) begin
                    state_d = ST_MENU;
                end
            end
            default: state_d = ST_PIN;
        endcase
    end

    // outputs
    always_comb begin
        disp_amount = '0;
        msg_code    = res_msg_q;
        blink       = 1'b0;
        unique case (state_q)
            ST_PIN: begin
                msg_code = res_msg_q;
            end
            ST_MENU: begin
                msg_code = MSG_MENU_BASE + {1'b0, svc_q};
            end
            ST_WDR, ST_DEP: begin
                msg_code    = MSG_ENTER;
                disp_amount = acc_total;
            end
            ST_CHK, ST_NEWPIN: begin
                msg_code = MSG_ENTER;
            end
            ST_BLINK: begin
                msg_code    = MSG_CONFIRM;
                disp_amount = shown_q;
                blink       = 1'b1;
            end
            ST_RESULT: begin
                msg_code    = res_msg_q;
                disp_amount = balance_q;
            end
            default: msg_code = res_msg_q;
        endcase
    end
endmodule

// File: rtl/atm_ctrl_chk.sv
module atm_ctrl_chk
    import atm_pkg::*;
#(
    parameter int AMT_W       = 11,
    parameter int MAX_BALANCE = 1500,
    parameter int WDR_LIMIT   = 500,
    parameter int WDR_STEP    = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AMT_W-1:0] disp_amount,
    input logic [3:0]       msg_code,
    input logic             blink,
    input logic [AMT_W-1:0] balance
);
    logic [AMT_W-1:0] prev_bal;
    logic [AMT_W-1:0] drop;

    always_ff @(posedge clk) begin
        prev_bal <= balance;
    end

    assign drop = prev_bal - balance;

    // R8
    blink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink && $past(blink)) |-> ($stable(balance) && $stable(disp_amount)));

    // R8
    blink_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blink) |-> (msg_code == MSG_BALANCE && disp_amount == balance));

    // R9
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (balance > prev_bal) |-> (balance <= AMT_W'(MAX_BALANCE)));

    // R6
    wdr_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (balance < prev_bal) |->
            (((drop % AMT_W'(WDR_STEP)) == '0) && (drop <= AMT_W'(WDR_LIMIT))));

    // R7
    funds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_code == MSG_ERR_FUNDS && $past(msg_code) != MSG_ERR_FUNDS) |-> $stable(balance));

    // R5
    entry_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_code == MSG_ENTER && $past(msg_code) == MSG_ENTER) |->
            (disp_amount >= $past(disp_amount)));
endmodule

bind atm_ctrl atm_ctrl_chk #(
    .AMT_W       (AMT_W),
    .MAX_BALANCE (MAX_BALANCE),
    .WDR_LIMIT   (WDR_LIMIT),
    .WDR_STEP    (WDR_STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_amount (disp_amount),
    .msg_code    (msg_code),
    .blink       (blink),
    .balance     (balance_q)
);

// File: tb/atm_ctrl_tb.sv
module atm_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BLINK_N    = 8;
    localparam int INIT_BAL   = 300;

    localparam int B_UP = 1, B_DOWN = 2, B_LEFT = 3, B_RIGHT = 4, B_CTR = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sw = '0;
    logic        btn_up = 1'b0, btn_down = 1'b0, btn_left = 1'b0;
    logic        btn_right = 1'b0, btn_ctr = 1'b0;
    logic [10:0] disp_amount;
    logic [3:0]  msg_code;
    logic        blink;

    always #(CLK_PERIOD / 2) clk = ~clk;

    atm_ctrl #(
        .BLINK_CYCLES (BLINK_N),
        .INIT_BALANCE (INIT_BAL)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw          (sw),
        .btn_up      (btn_up),
        .btn_down    (btn_down),
        .btn_left    (btn_left),
        .btn_right   (btn_right),
        .btn_ctr     (btn_ctr),
        .disp_amount (disp_amount),
        .msg_code    (msg_code),
        .blink       (blink)
    );

    typedef struct packed {
        logic [3:0]  msg;
        logic [10:0] amt;
        logic        blk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  mon_ev;
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;

    // bench model
    int m_bal = INIT_BAL;
    int m_pin = 0;
    int m_svc = 0;
    int m_acc = 0;

    // monitor: pops expectations and compares against the ports
    always begin
        @(mon_ev);
        while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (msg_code !== e.msg || disp_amount !== e.amt || blink !== e.blk) begin
                n_fails++;
                $display("FAIL %s: got msg=%0d amt=%0d blink=%0b, expected msg=%0d amt=%0d blink=%0b",
                         t, msg_code, disp_amount, blink, e.msg, e.amt, e.blk);
            end
        end
    end

    task automatic expect_now(input string t, input int msg, input int amt, input bit blk);
        exp_t e;
        e.msg = 4'(msg);
        e.amt = 11'(amt);
        e.blk = blk;
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> mon_ev;
    endtask

    task automatic press(input int b);
        @(negedge clk);
        btn_up    = (b == B_UP);
        btn_down  = (b == B_DOWN);
        btn_left  = (b == B_LEFT);
        btn_right = (b == B_RIGHT);
        btn_ctr   = (b == B_CTR);
        @(negedge clk);
        btn_up = 1'b0; btn_down = 1'b0; btn_left = 1'b0;
        btn_right = 1'b0; btn_ctr = 1'b0;
    endtask

    task automatic menu_goto(input int target);
        while (m_svc != target) begin
            press(B_UP);
            m_svc = (m_svc + 1) % 5;
            expect_now("R3 menu step", 1 + m_svc, 0, 1'b0);
        end
    endtask

    task automatic back_to_menu();
        press(B_CTR);
        expect_now("R4 return to menu", 1 + m_svc, 0, 1'b0);
    endtask

    task automatic blink_seq(input string t, input int amt);
        expect_now(t, 8, amt, 1'b1);
        repeat (BLINK_N - 1) @(negedge clk);
        expect_now(t, 8, amt, 1'b1);
        @(negedge clk);
        expect_now(t, 6, m_bal, 1'b0);
    endtask

    task automatic enter_amount(input int b, input int n);
        for (int i = 0; i < n; i++) begin
            int v;
            press(b);
            v = (b == B_UP) ? 10 : (b == B_RIGHT) ? 20 : (b == B_LEFT) ? 50 : 100;
            m_acc = (m_acc + v > 2047) ? 2047 : m_acc + v;
            expect_now("R5 running total", 7, m_acc, 1'b0);
        end
    endtask

    task automatic open_entry();
        press(B_CTR);
        m_acc = 0;
        expect_now("R5 entry opens at 0", 7, 0, 1'b0);
    endtask

    task automatic commit_wdr();
        press(B_CTR);
        if ((m_acc % 20) != 0 || m_acc > 500) begin
            expect_now("R6 bad withdrawal amount", 10, m_bal, 1'b0);
        end else if (m_acc > m_bal) begin
            expect_now("R7 insufficient funds", 11, m_bal, 1'b0);
        end else begin
            m_bal = m_bal - m_acc;
            blink_seq("R8 withdrawal confirm", m_acc);
        end
    endtask

    task automatic commit_dep();
        press(B_CTR);
        if (m_bal + m_acc > 1500) begin
            expect_now("R9 deposit ceiling", 12, m_bal, 1'b0);
        end else begin
            m_bal = m_bal + m_acc;
            blink_seq("R10 deposit confirm", m_acc);
        end
    endtask

    task automatic commit_chk(input logic [15:0] digits, input int value, input bit ok);
        sw = digits;
        press(B_CTR);
        if (!ok) begin
            expect_now("R11 bad BCD digit", 14, m_bal, 1'b0);
        end else if (m_bal + value > 1500) begin
            expect_now("R9 check over ceiling", 12, m_bal, 1'b0);
        end else begin
            m_bal = m_bal + value;
            blink_seq("R11 check confirm", value);
        end
    endtask

    task automatic commit_pin(input int newpin);
        sw = 16'(newpin);
        press(B_CTR);
        if (newpin == m_pin) begin
            expect_now("R12 same PIN rejected", 13, m_bal, 1'b0);
        end else begin
            m_pin = newpin;
            expect_now("R12 PIN stored", 15, m_bal, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_now("R1 reset state", 0, 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 idle after reset", 0, 0, 1'b0);

        // R2 wrong then correct PIN (stored PIN is 8'h00 after reset, R1)
        sw = 16'h0005;
        press(B_CTR);
        expect_now("R2 wrong PIN", 9, 0, 1'b0);
        sw = 16'h0000;
        press(B_CTR);
        m_svc = 0;
        expect_now("R2 PIN accepted", 1, 0, 1'b0);

        // R3 wrap both ways
        menu_goto(4);
        press(B_UP);
        m_svc = 0;
        expect_now("R3 up wraps", 1, 0, 1'b0);
        press(B_DOWN);
        m_svc = 4;
        expect_now("R3 down wraps", 5, 0, 1'b0);
        press(B_DOWN);
        m_svc = 3;
        expect_now("R3 down step", 4, 0, 1'b0);

        // R4 balance inquiry
        menu_goto(0);
        press(B_CTR);
        expect_now("R4 balance shown", 6, m_bal, 1'b0);
        press(B_LEFT);
        expect_now("R4 button ignored on result", 6, m_bal, 1'b0);
        back_to_menu();

        // withdrawals
        menu_goto(1);
        open_entry();
        enter_amount(B_UP, 1);
        commit_wdr();
        back_to_menu();
        open_entry();
        enter_amount(B_DOWN, 6);
        commit_wdr();
        back_to_menu();
        open_entry();
        enter_amount(B_DOWN, 4);
        commit_wdr();
        back_to_menu();
        open_entry();
        enter_amount(B_DOWN, 1);
        enter_amount(B_LEFT, 1);
        enter_amount(B_UP, 1);
        commit_wdr();
        back_to_menu();
        open_entry();
        enter_amount(B_DOWN, 21);
        commit_wdr();
        back_to_menu();

        // deposits
        menu_goto(2);
        open_entry();
        enter_amount(B_DOWN, 14);
        commit_dep();
        back_to_menu();
        open_entry();
        enter_amount(B_LEFT, 1);
        enter_amount(B_RIGHT, 1);
        commit_dep();
        back_to_menu();

        // check deposit
        menu_goto(3);
        open_entry();
        commit_chk(16'h00A0, 0, 1'b0);
        back_to_menu();
        open_entry();
        commit_chk(16'h2000, 2000, 1'b1);
        back_to_menu();
        open_entry();
        commit_chk(16'h0125, 125, 1'b1);
        back_to_menu();

        // PIN change
        menu_goto(4);
        open_entry();
        commit_pin(0);
        back_to_menu();
        open_entry();
        commit_pin(8'h3C);
        back_to_menu();
        open_entry();
        commit_pin(8'h3C);
        back_to_menu();

        // final balance through inquiry
        menu_goto(0);
        press(B_CTR);
        expect_now("R4 final balance", 6, m_bal, 1'b0);

        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule